// File: doc/BRIEF.md
# PDM Microphone Receiver with Ones-Count Decimation

This block connects a one-bit pulse-density-modulated digital microphone to a system running on a faster clock. It generates the microphone's bit clock by integer division of the system clock. It then takes one bit from the microphone's data line per bit-clock period. That data line first passes through a two-flop synchronizer.

The sampling moment is the low-to-high or the high-to-low transition of the generated clock, chosen by a channel-select input. A microphone wired for one channel drives valid data for one of these transitions. A microphone wired for the other channel drives it for the other.

The recovered sample is the number of '1' bits seen over a window of 2^k bit-clock periods, with k at most 8. At each window boundary the count is published on the PCM output together with a one-cycle valid strobe. The counter then restarts with no bit skipped. Changes to channel select or window length are picked up only at a window boundary, so a window never mixes two settings. Reset holds the bit clock low and clears the count and the output.

Top module: `pdm_mic_rx`

## Requirements
- R1: The generated mic_clk stays high for H system clock cycles and then low for H cycles, where H is half_div, and a half_div of 0 counts as 1. At a 50 MHz system clock, half_div values 8 to 25 keep mic_clk between 1 MHz and 3.3 MHz.
- R2: While rst_n is low, and in the first cycle after it rises, mic_clk is 0, pcm is 0 and pcm_valid is 0.
- R3: With chan_sel = 0, a bit is taken at each low-to-high transition of mic_clk. The value taken is the one mic_data held during the preceding low phase.
- R4: With chan_sel = 1, a bit is taken at each high-to-low transition of mic_clk. The value taken is the one mic_data held during the preceding high phase.
- R5: pcm equals the number of '1' bits among the 2^win_log bits of one window. A window of all ones gives 2^win_log, all zeros gives 0, and alternating bits give half the window.
- R6: A win_log value above 8 is treated as 8, which gives a 256-bit window whose all-ones count of 256 is held without overflow.
- R7: pcm_valid is high for exactly one system clock cycle per window. Under fixed settings, consecutive strobes are exactly 2^win_log x 2 x H system cycles apart, so no bit is lost at a boundary.
- R8: A change of chan_sel or win_log in the middle of a window does not affect that window. It applies from the next window on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_div | input | DIV_W (8) | Half period of mic_clk, in system clock cycles |
| chan_sel | input | 1 | Sampling transition: 0 = low-to-high, 1 = high-to-low |
| win_log | input | 4 | Base-2 logarithm of the window length in bits (clamped to 8) |
| mic_clk | output | 1 | Bit clock to the microphone |
| mic_data | input | 1 | One-bit data from the microphone (asynchronous) |
| pcm | output | 9 | Ones count of the last completed window |
| pcm_valid | output | 1 | One-cycle strobe marking a new pcm value |

## Verification
The situations hardest to reach from the ports are the difference between the two sampling transitions and the deferred pickup of new settings. Data that does not move with the bit clock gives the same count for either transition. The bench therefore has a microphone model that drives mic_data from mic_clk itself. In one mode the data level copies the clock phase, so the two transitions give counts of zero and full scale. In another mode the data flips once per period. Settings are changed a few cycles after a strobe is observed, which is the middle of a window. The bench then requires the next count to still reflect the old setting and the one after it to reflect the new setting.

// File: rtl/pdm_rx_pkg.sv
// Package: shared types for the PDM microphone receiver.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pdm_rx_pkg;

    // Transition of the microphone clock at which a bit is taken.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/pdm_clk_div.sv
// Module: pdm_clk_div
// Divides the system clock into a 50%-duty microphone bit clock. Each phase
// lasts max(half_div,1) system cycles. Pulses rise_evt or fall_evt in the
// cycle whose closing edge flips the clock register.
// Assumes half_div is held stable by the integrator while running; a change
// takes effect at the latest at the end of the current phase.
module pdm_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    output logic             mic_clk,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] phase_cnt;
    logic [DIV_W-1:0] half_eff;
    logic             phase_end;
    logic             clk_q;

    // Effective half period: a zero setting behaves as one.
    always_comb begin
        half_eff  = (half_div == '0) ? DIV_W'(1) : half_div;
        phase_end = rst_n && (phase_cnt >= (half_eff - DIV_W'(1)));
        rise_evt  = phase_end && !clk_q;
        fall_evt  = phase_end && clk_q;
    end

    // Phase counter and clock register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_cnt <= '0;
            clk_q     <= 1'b0;
        end else if (phase_end) begin
            phase_cnt <= '0;
            clk_q     <= !clk_q;
        end else begin
            phase_cnt <= phase_cnt + DIV_W'(1);
        end
    end

    assign mic_clk = clk_q;

    AST_RISE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |=> mic_clk); // R1
    AST_FALL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        fall_evt |=> !mic_clk); // R1
    AST_NO_STRAY_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mic_clk) |-> $past(rise_evt || fall_evt)); // R1

endmodule

// File: rtl/pdm_sync.sv
// Module: pdm_sync
// Multi-flop synchronizer for the asynchronous microphone data line.
// Assumes STAGES >= 2; the output lags the input by STAGES system cycles.
module pdm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // One stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= 1'b0;
                end else if (s == 0) begin
                    chain[s] <= d_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/pdm_win_count.sv
// Module: pdm_win_count
// Counts '1' bits taken at the selected microphone clock transition over a
// window of 2^win bits and publishes the count with a one-cycle strobe.
// Channel select and window length are latched during reset and at each
// window boundary only. Assumes at least two system cycles per microphone
// clock period.
module pdm_win_count
    import pdm_rx_pkg::*;
#(
    parameter int WIN_LOG_MAX = 8,
    parameter int WSEL_W      = $clog2(WIN_LOG_MAX + 1),
    parameter int CNT_W       = WIN_LOG_MAX + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              bit_in,
    input  logic              chan_sel,
    input  logic [WSEL_W-1:0] win_log,
    output logic [CNT_W-1:0]  pcm,
    output logic              pcm_valid
);

    localparam logic [WSEL_W-1:0] WIN_CAP = WSEL_W'(WIN_LOG_MAX);
    localparam logic [CNT_W-1:0]  ONE     = CNT_W'(1);

    edge_sel_e         sel_q;
    logic [WSEL_W-1:0] win_q;
    logic [WSEL_W-1:0] win_clamped;
    logic [CNT_W-1:0]  win_last;
    logic [CNT_W-1:0]  samp_cnt;
    logic [CNT_W-1:0]  ones_cnt;
    logic              take;
    logic              boundary;

    // Clamp the requested window, find the last index and the sampling strobe.
    always_comb begin
        win_clamped = (win_log > WIN_CAP) ? WIN_CAP : win_log;
        win_last    = (ONE << win_q) - ONE;
        take        = (sel_q == EDGE_FALL) ? fall_evt : rise_evt;
        boundary    = take && (samp_cnt == win_last);
    end

    // Window counters, output register and boundary latching of settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_cnt  <= '0;
            ones_cnt  <= '0;
            pcm       <= '0;
            pcm_valid <= 1'b0;
            sel_q     <= edge_sel_e'(chan_sel);
            win_q     <= win_clamped;
        end else begin
            pcm_valid <= 1'b0;
            if (boundary) begin
                pcm       <= ones_cnt + CNT_W'(bit_in);
                pcm_valid <= 1'b1;
                samp_cnt  <= '0;
                ones_cnt  <= '0;
                sel_q     <= edge_sel_e'(chan_sel);
                win_q     <= win_clamped;
            end else if (take) begin
                samp_cnt  <= samp_cnt + ONE;
                ones_cnt  <= ones_cnt + CNT_W'(bit_in);
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ones_cnt <= samp_cnt); // R5
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |=> !pcm_valid); // R7
    AST_CFG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sel_q) || !$stable(win_q)) |-> pcm_valid); // R8
    AST_WIN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_valid |-> (pcm <= (ONE << win_q) || !$stable(win_q))); // R6

endmodule

// File: rtl/pdm_mic_rx.sv
// Module: pdm_mic_rx (top)
// PDM microphone receiver: bit clock generation, data synchronization and
// ones-count decimation over a programmable power-of-two window.
// Assumes half_div >= 3 so that the synchronizer latency stays inside
// one clock phase.
module pdm_mic_rx #(
    parameter int DIV_W       = 8,
    parameter int WIN_LOG_MAX = 8,
    parameter int SYNC_STAGES = 2,
    parameter int WSEL_W      = $clog2(WIN_LOG_MAX + 1),
    parameter int CNT_W       = WIN_LOG_MAX + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              chan_sel,
    input  logic [WSEL_W-1:0] win_log,
    output logic              mic_clk,
    input  logic              mic_data,
    output logic [CNT_W-1:0]  pcm,
    output logic              pcm_valid
);

    logic rise_evt;
    logic fall_evt;
    logic data_sync;

    pdm_clk_div #(.DIV_W(DIV_W)) u_clk_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_div (half_div),
        .mic_clk  (mic_clk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    pdm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (mic_data),
        .d_sync  (data_sync)
    );

    pdm_win_count #(
        .WIN_LOG_MAX (WIN_LOG_MAX),
        .WSEL_W      (WSEL_W),
        .CNT_W       (CNT_W)
    ) u_win_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .bit_in    (data_sync),
        .chan_sel  (chan_sel),
        .win_log   (win_log),
        .pcm       (pcm),
        .pcm_valid (pcm_valid)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!mic_clk && !pcm_valid && pcm == '0)); // R2

endmodule

// File: tb/pdm_mic_rx_bench.sv
`timescale 1ns/1ps
// Directed bench for pdm_mic_rx: one task per scenario, each checking itself.
module pdm_mic_rx_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] half_div = 8'd10;
    logic       chan_sel = 1'b0;
    logic [3:0] win_log = 4'd3;
    logic       mic_clk;
    logic       mic_data;
    logic [8:0] pcm;
    logic       pcm_valid;

    int checks = 0;
    int errors = 0;
    int cycle  = 0;
    int mode   = 0;      // 0 constant, 1 follows clock phase, 2 flips per period
    logic const_val = 1'b0;
    logic data_drv  = 1'b0;
    logic tog       = 1'b0;

    always #10 clk = !clk;
    always @(posedge clk) cycle <= cycle + 1;

    assign mic_data = (mode == 0) ? const_val : data_drv;

    // Microphone model: data changes shortly after each mic clock transition.
    always @(mic_clk) begin
        #1;
        if (mic_clk) tog = !tog;
        data_drv = (mode == 1) ? mic_clk : tog;
    end

    pdm_mic_rx u_pdm_mic_rx (
        .clk (clk), .rst_n (rst_n), .half_div (half_div), .chan_sel (chan_sel),
        .win_log (win_log), .mic_clk (mic_clk), .mic_data (mic_data),
        .pcm (pcm), .pcm_valid (pcm_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int h, input bit sel, input int w);
        @(negedge clk);
        rst_n = 1'b0; half_div = 8'(h); chan_sel = sel; win_log = 4'(w);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_valid(output int val, output int stamp);
        val = -1; stamp = -1;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (pcm_valid) begin
                val = int'(pcm); stamp = cycle;
                return;
            end
        end
        chk(1'b0, "timeout waiting for pcm_valid", 0, 1);
    endtask

    task automatic t_reset();
        int v, s;
        mode = 0; const_val = 1'b1;
        do_reset(10, 0, 2);
        wait_valid(v, s);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(!mic_clk && !pcm_valid, "R2 idle in reset (mic_clk,valid)", {mic_clk, pcm_valid}, 0);
        chk(pcm == 0, "R2 pcm cleared in reset", int'(pcm), 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(!mic_clk && pcm == 0 && !pcm_valid, "R2 first cycle after reset",
            int'(pcm) + int'(mic_clk), 0);
    endtask

    task automatic t_period(input int h);
        int hi, lo;
        do_reset(h, 0, 3);
        while (mic_clk !== 1'b1) @(negedge clk);
        hi = 0;
        while (mic_clk === 1'b1) begin hi++; @(negedge clk); end
        lo = 0;
        while (mic_clk === 1'b0) begin lo++; @(negedge clk); end
        chk(hi == h, "R1 high phase length", hi, h);
        chk(lo == h, "R1 low phase length", lo, h);
    endtask

    task automatic t_const(input bit lvl, input int w, input int exp);
        int v, s;
        mode = 0; const_val = lvl;
        do_reset(8, 0, w);
        wait_valid(v, s);
        chk(v == exp, "R5 constant-level count", v, exp);
    endtask

    task automatic t_clamp();
        int v, s;
        mode = 0; const_val = 1'b1;
        do_reset(8, 1, 15);
        wait_valid(v, s);
        chk(v == 256, "R6 window clamped to 256", v, 256);
    endtask

    task automatic t_edge(input bit sel, input int exp, input string tag);
        int v, s;
        mode = 1;
        do_reset(10, sel, 3);
        wait_valid(v, s);
        wait_valid(v, s);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic t_alternate(input bit sel);
        int v, s;
        mode = 2;
        do_reset(9, sel, 3);
        wait_valid(v, s);
        wait_valid(v, s);
        chk(v == 4, "R5 alternating bits give half window", v, 4);
    endtask

    task automatic t_cadence();
        int v, s1, s2;
        mode = 0; const_val = 1'b1;
        do_reset(10, 0, 2);
        wait_valid(v, s1);
        @(negedge clk);
        chk(pcm_valid == 1'b0, "R7 strobe lasts one cycle", int'(pcm_valid), 0);
        wait_valid(v, s2);
        chk(s2 - s1 == 80, "R7 strobe spacing", s2 - s1, 80);
        chk(v == 4, "R7 no bit lost across boundary", v, 4);
    endtask

    task automatic t_win_change();
        int v, s;
        mode = 0; const_val = 1'b1;
        do_reset(8, 0, 2);
        wait_valid(v, s);
        repeat (5) @(negedge clk);
        win_log = 4'd4;
        wait_valid(v, s);
        chk(v == 4, "R8 window in progress keeps old length", v, 4);
        wait_valid(v, s);
        chk(v == 16, "R8 new length from next window", v, 16);
    endtask

    task automatic t_sel_change();
        int v, s;
        mode = 1;
        do_reset(10, 0, 2);
        wait_valid(v, s);
        repeat (5) @(negedge clk);
        chan_sel = 1'b1;
        wait_valid(v, s);
        chk(v == 0, "R8 window in progress keeps old transition", v, 0);
        wait_valid(v, s);
        chk(v == 4, "R8 new transition from next window", v, 4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycle > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycle);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Scenario sequence.
    initial begin
        t_reset();
        t_period(10);
        t_period(13);
        t_period(0 + 25);
        t_const(1'b1, 3, 8);
        t_const(1'b0, 3, 0);
        t_const(1'b1, 0, 1);
        t_const(1'b1, 8, 256);
        t_clamp();
        t_edge(1'b0, 0, "R3 rising transition takes low-phase data");
        t_edge(1'b1, 8, "R4 falling transition takes high-phase data");
        t_alternate(1'b0);
        t_alternate(1'b1);
        t_cadence();
        t_win_change();
        t_sel_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule